// File: doc/BRIEF.md
# ADC Sample Gain and Ring-Buffer Writer

This block sits between an ADC front end and on-chip sample memory. Each conversion result that arrives is multiplied by a programmable gain. The product is clamped to the signed 16-bit range. When the buffer writer is switched on, the corrected sample goes through a one-word write port into a circular region of memory, which is defined by a base address and a length in samples. Results that arrive while the writer is switched off are discarded, and that loss is recorded.

Four sticky event flags record what happened: the first half of the ring was completed, the whole ring was completed, the gain stage clamped a sample, or a result was lost. Software clears a flag by writing 1 to its bit. A separate mask selects which flags drive the single registered interrupt line. With an all-zero mask, software polls the flags instead. All configuration is done over a small word-addressed register bus. Writes take effect on the clock edge, and reads are combinational.

Top module: `adc_dma_writer`

## Requirements
- R1: The corrected sample equals floor(raw × gain / 32768). The raw sample is signed 16-bit. The gain register (bus address 1) is unsigned, with 0x8000 meaning ×1, and resets to 0x8000.
- R2: A result above 32767 is written as 0x7FFF, and a result below −32768 is written as 0x8000. Any clamped conversion sets flag bit 2, whether the writer is on or off.
- R3: While the enable bit is set (bit 0 at bus address 0), each valid sample is written one cycle later on the memory write port. The write address is (base + index) modulo 2^ADDR_W. The index steps by one and returns to 0 after index length−1. The base is at bus address 2, and the length is at bus address 3 (reset value 16, must be even and ≥2).
- R4: A bus write that changes the enable bit from 0 to 1 resets the index, so the next write goes to the base address.
- R5: A valid sample that arrives while the writer is off produces no memory write and sets flag bit 3.
- R6: A write at index length/2−1 sets flag bit 0.
- R7: A write at index length−1 sets flag bit 1.
- R8: The flags are at bus address 4. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set event and a clear of the same bit occur in the same cycle, the bit stays set.
- R9: The irq output equals the OR of (flags AND mask), registered. It follows any flag or mask change one cycle later. The mask is bits 3:0 at bus address 5, and a zero mask keeps irq low.
- R10: Reads return the control, gain, base, length, flag and mask registers, zero-extended to 16 bits. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Conversion result valid this cycle |
| smp_data | input | 16 | Signed raw conversion result |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational) |
| mem_we | output | 1 | Sample memory write strobe |
| mem_addr | output | ADDR_W | Sample memory write address |
| mem_wdata | output | 16 | Corrected sample to memory |
| irq | output | 1 | Masked event interrupt request |

## Verification
The embedded assertions check the following properties on every cycle:
- a write follows every accepted sample, and no write follows a dropped one;
- the index returns to zero after the last slot and after an enable;
- a set event always wins over a clear, and write-1 clears work correctly;
- irq tracks the masked flags one cycle later;
- a clamped output is always one of the two rail values.

Some behaviour can only be shown by the bench's scenarios. These include the exact product and floor rounding for chosen gains, the slot where the half-full and full flags fire for a given length, and the address wrapping past the top of memory. They also include the restart on re-enable and the interaction of disable, overflow and polled mode over longer stretches.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;
  localparam int SMP_W  = 16;
  localparam int FLAG_N = 4;
  localparam int FLG_HALF = 0;
  localparam int FLG_FULL = 1;
  localparam int FLG_SAT  = 2;
  localparam int FLG_OVF  = 3;

  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_GAIN  = 3'd1,
    RG_BASE  = 3'd2,
    RG_LEN   = 3'd3,
    RG_FLAGS = 3'd4,
    RG_MASK  = 3'd5
  } reg_sel_e;

  // Returns {clamped, corrected sample}
  function automatic logic [SMP_W:0] gain_apply(input logic [SMP_W-1:0] raw,
                                                input logic [SMP_W-1:0] gain);
    logic signed [33:0] a;
    logic signed [33:0] b;
    logic signed [33:0] prod;
    logic signed [33:0] sh;
    logic [SMP_W:0]     res;
    a    = {{18{raw[SMP_W-1]}}, raw};
    b    = {18'd0, gain};
    prod = a * b;
    sh   = prod >>> 15;
    if (sh > 34'sd32767)       res = {1'b1, 16'h7FFF};
    else if (sh < -34'sd32768) res = {1'b1, 16'h8000};
    else                       res = {1'b0, sh[SMP_W-1:0]};
    return res;
  endfunction
endpackage

// File: rtl/adc_gain_stage.sv
module adc_gain_stage
  import adc_dma_pkg::*;
(
  input  logic [SMP_W-1:0] raw_i,
  input  logic [SMP_W-1:0] gain_i,
  output logic [SMP_W-1:0] corr_o,
  output logic             sat_o
);
  logic [SMP_W:0] res;

  always_comb begin
    res    = gain_apply(raw_i, gain_i);
    sat_o  = res[SMP_W];
    corr_o = res[SMP_W-1:0];
  end

  // a clamped result is always one of the two rails
  always_comb begin
    if (sat_o) begin
      assert_clamp_rail_R2: assert (corr_o == 16'h7FFF || corr_o == 16'h8000);
    end
  end
endmodule

// File: rtl/adc_buf_ptr.sv
module adc_buf_ptr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] len_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic              half_ev_o,
  output logic              full_ev_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] idx_q;
  logic [ADDR_W-1:0] last_idx;
  logic [ADDR_W-1:0] half_idx;

  assign last_idx  = len_i - ONE;
  assign half_idx  = (len_i >> 1) - ONE;
  assign half_ev_o = advance_i && (idx_q == half_idx);
  assign full_ev_o = advance_i && (idx_q == last_idx);
  assign idx_o     = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (restart_i)  idx_q <= '0;
    else if (advance_i)  idx_q <= full_ev_o ? '0 : idx_q + ONE;
  end

  assert_wrap_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ev_o && !restart_i) |=> (idx_q == '0));

  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (idx_q == '0));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !full_ev_o && !restart_i) |=> (idx_q == $past(idx_q) + ONE));
endmodule

// File: rtl/adc_irq_regs.sv
module adc_irq_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_data_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_data_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] clr_eff;
  logic         irq_q;

  assign clr_eff = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_eff) | set_ev_i;
      if (mask_we_i) mask_q <= mask_data_i;
      irq_q   <= |(flags_q & mask_q);
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ev_i) |=> (($past(set_ev_i) & ~flags_q) == '0));

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> (($past(clr_data_i & ~set_ev_i) & flags_q) == '0));

  assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> (($past(flags_q & ~clr_data_i) & ~flags_q) == '0));

  assert_irq_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & mask_q)) |=> irq_q);

  assert_irq_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & mask_q) == '0) |=> !irq_q);
endmodule

// File: rtl/adc_dma_writer.sv
module adc_dma_writer
  import adc_dma_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [15:0]       smp_data,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] LEN_RST = ADDR_W'(16);

  logic              en_q;
  logic [15:0]       gain_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] len_q;

  logic              wr_ctrl, wr_gain, wr_base, wr_len, wr_flags, wr_mask;
  logic              restart, advance;
  logic              sat, sat_ev, ovf_ev, half_ev, full_ev;
  logic [15:0]       corr;
  logic [ADDR_W-1:0] idx;
  logic [FLAG_N-1:0] set_ev;
  logic [FLAG_N-1:0] flags, mask;

  logic              mem_we_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [15:0]       mem_wdata_q;

  assign wr_ctrl  = bus_we && (bus_addr == RG_CTRL);
  assign wr_gain  = bus_we && (bus_addr == RG_GAIN);
  assign wr_base  = bus_we && (bus_addr == RG_BASE);
  assign wr_len   = bus_we && (bus_addr == RG_LEN);
  assign wr_flags = bus_we && (bus_addr == RG_FLAGS);
  assign wr_mask  = bus_we && (bus_addr == RG_MASK);

  assign restart = wr_ctrl && bus_wdata[0] && !en_q;
  assign advance = smp_valid && en_q;
  assign ovf_ev  = smp_valid && !en_q;
  assign sat_ev  = smp_valid && sat;

  always_comb begin
    set_ev           = '0;
    set_ev[FLG_HALF] = half_ev;
    set_ev[FLG_FULL] = full_ev;
    set_ev[FLG_SAT]  = sat_ev;
    set_ev[FLG_OVF]  = ovf_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      gain_q <= 16'h8000;
      base_q <= '0;
      len_q  <= LEN_RST;
    end else begin
      if (wr_ctrl) en_q   <= bus_wdata[0];
      if (wr_gain) gain_q <= bus_wdata;
      if (wr_base) base_q <= bus_wdata[ADDR_W-1:0];
      if (wr_len)  len_q  <= bus_wdata[ADDR_W-1:0];
    end
  end

  adc_gain_stage u_gain (
    .raw_i  (smp_data),
    .gain_i (gain_q),
    .corr_o (corr),
    .sat_o  (sat)
  );

  adc_buf_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .advance_i (advance),
    .len_i     (len_q),
    .idx_o     (idx),
    .half_ev_o (half_ev),
    .full_ev_o (full_ev)
  );

  adc_irq_regs #(.N(FLAG_N)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_ev_i    (set_ev),
    .clr_we_i    (wr_flags),
    .clr_data_i  (bus_wdata[FLAG_N-1:0]),
    .mask_we_i   (wr_mask),
    .mask_data_i (bus_wdata[FLAG_N-1:0]),
    .flags_o     (flags),
    .mask_o      (mask),
    .irq_o       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      mem_we_q <= advance;
      if (advance) begin
        mem_addr_q  <= base_q + idx;
        mem_wdata_q <= corr;
      end
    end
  end

  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;

  always_comb begin
    case (bus_addr)
      RG_CTRL:  bus_rdata = {15'd0, en_q};
      RG_GAIN:  bus_rdata = gain_q;
      RG_BASE:  bus_rdata = 16'(base_q);
      RG_LEN:   bus_rdata = 16'(len_q);
      RG_FLAGS: bus_rdata = 16'(flags);
      RG_MASK:  bus_rdata = 16'(mask);
      default:  bus_rdata = 16'd0;
    endcase
  end

  assert_no_write_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !en_q) |=> !mem_we);

  assert_write_when_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && en_q) |=> (mem_we && mem_wdata == $past(corr)));

  assert_overflow_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !en_q) |=> flags[FLG_OVF]);
endmodule

// File: tb/adc_dma_writer_tb.sv
module adc_dma_writer_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [15:0]   smp_data = '0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = 3'd4;
  logic [15:0]   bus_wdata = '0;
  logic [15:0]   bus_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic          irq;

  always #2.5 clk = ~clk;

  adc_dma_writer #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_en;
  int unsigned m_gain, m_base, m_len, m_idx;
  bit [3:0]    m_flags, m_mask;
  bit          m_irq, m_we;
  int unsigned m_addr, m_wdata;

  function automatic int unsigned ref_gain(input logic [15:0] raw, input int unsigned g,
                                           output bit clamped);
    longint p;
    longint q;
    p = longint'($signed(raw)) * longint'(g);
    q = p >>> 15;
    clamped = 1'b0;
    if (q > 32767)  begin q = 32767;  clamped = 1'b1; end
    if (q < -32768) begin q = -32768; clamped = 1'b1; end
    return int'(q) & 32'hFFFF;
  endfunction

  function automatic int unsigned ref_read(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_en};
      3'd1: return m_gain;
      3'd2: return m_base;
      3'd3: return m_len;
      3'd4: return {28'd0, m_flags};
      3'd5: return {28'd0, m_mask};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [3:0] set;
    bit [3:0] clr;
    bit clamped;
    int unsigned v;
    if (!rst_n) begin
      m_en = 0; m_gain = 32'h8000; m_base = 0; m_len = 16; m_idx = 0;
      m_flags = 0; m_mask = 0; m_irq = 0; m_we = 0; m_addr = 0; m_wdata = 0;
    end else begin
      m_irq = |(m_flags & m_mask);
      set = 0;
      m_we = 0;
      if (smp_valid) begin
        v = ref_gain(smp_data, m_gain, clamped);
        if (clamped) set[2] = 1;
        if (m_en) begin
          m_we = 1;
          m_addr = (m_base + m_idx) % (1 << AW);
          m_wdata = v;
          if (m_idx == m_len / 2 - 1) set[0] = 1;
          if (m_idx == m_len - 1) begin set[1] = 1; m_idx = 0; end
          else m_idx = (m_idx + 1) % (1 << AW);
        end else set[3] = 1;
      end
      clr = (bus_we && bus_addr == 3'd4) ? bus_wdata[3:0] : 4'd0;
      m_flags = (m_flags & ~clr) | set;
      if (bus_we) begin
        case (bus_addr)
          3'd0: begin if (bus_wdata[0] && !m_en) m_idx = 0; m_en = bus_wdata[0]; end
          3'd1: m_gain = bus_wdata;
          3'd2: m_base = bus_wdata[AW-1:0];
          3'd3: m_len = bus_wdata[AW-1:0];
          3'd5: m_mask = bus_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input int unsigned act, input int unsigned exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(mem_we, m_we, "R3/R5 mem_we");
    if (m_we) begin
      chk(mem_addr, m_addr, "R3 mem_addr");
      chk(mem_wdata, m_wdata, "R1/R2 mem_wdata");
    end
    chk(irq, m_irq, "R9 irq");
    chk(bus_rdata, ref_read(bus_addr), "R10/R8 bus_rdata");
  endtask

  task automatic cyc(input bit v, input logic [15:0] d, input bit we,
                     input logic [2:0] a, input logic [15:0] wd);
    smp_valid = v; smp_data = d; bus_we = we; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] wd);
    cyc(0, 0, 1, a, wd);
  endtask

  task automatic rd(input logic [2:0] a);
    cyc(0, 0, 0, a, 0);
  endtask

  task automatic smp(input logic [15:0] d);
    cyc(1, d, 0, 3'd4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // reset values
    rd(3'd1); chk(bus_rdata, 16'h8000, "R10 gain reset");
    rd(3'd3); chk(bus_rdata, 16, "R10 len reset");
    rd(3'd4); chk(bus_rdata, 0, "R8 flags reset");
    chk(irq, 0, "R9 irq reset");
    rd(3'd6); chk(bus_rdata, 0, "R10 unmapped read");

    // polled run: base 0x10, length 8
    wr(3'd2, 16'h0010);
    wr(3'd3, 16'd8);
    wr(3'd0, 16'd1);
    for (int i = 0; i < 4; i++) smp(16'(i * 100));
    chk(mem_wdata, 300, "R1 unity gain");
    rd(3'd4); chk(bus_rdata[1:0], 2'b01, "R6 half flag only");
    for (int i = 0; i < 4; i++) smp(16'(i + 7));
    rd(3'd4); chk(bus_rdata[1:0], 2'b11, "R7 full flag");
    chk(irq, 0, "R9 zero mask stays low");
    smp(16'h0042);
    chk(mem_addr, 8'h10, "R3 wrap to base");
    wr(3'd4, 16'h0000); rd(3'd4); chk(bus_rdata[1:0], 2'b11, "R8 write zero keeps");
    wr(3'd4, 16'h0001); rd(3'd4); chk(bus_rdata[1:0], 2'b10, "R8 write one clears");
    wr(3'd4, 16'h000F);

    // gain arithmetic
    wr(3'd1, 16'h4000);
    smp(16'd100);          chk(mem_wdata, 50, "R1 half gain");
    smp(16'hFFFD);         chk(mem_wdata, 16'hFFFE, "R1 floor of -1.5");
    wr(3'd1, 16'hFFFF);
    smp(16'h7000);         chk(mem_wdata, 16'h7FFF, "R2 positive clamp");
    smp(16'h9000);         chk(mem_wdata, 16'h8000, "R2 negative clamp");
    rd(3'd4); chk(bus_rdata[2], 1, "R2 sat flag");

    // overflow while disabled, then restart at base
    wr(3'd4, 16'h000F);
    wr(3'd0, 16'd0);
    smp(16'd5);            chk(mem_we, 0, "R5 no write when off");
    rd(3'd4); chk(bus_rdata[3], 1, "R5 overflow flag");
    smp(16'h7000);         rd(3'd4); chk(bus_rdata[2], 1, "R2 sat while off");
    wr(3'd0, 16'd1);
    smp(16'd9);            chk(mem_addr, 8'h10, "R4 restart at base");

    // interrupt mask and set-wins
    wr(3'd4, 16'h000F);
    wr(3'd5, 16'h0004);
    chk(irq, 0, "R9 masked flags clear");
    cyc(1, 16'h7000, 1, 3'd4, 16'h0004);
    chk(bus_rdata[2], 1, "R8 set beats clear");
    rd(3'd4);
    chk(irq, 1, "R9 irq one cycle later");
    wr(3'd5, 16'h0000);
    rd(3'd4); chk(irq, 0, "R9 mask off drops irq");

    // address wrap across the top of memory
    wr(3'd0, 16'd0);
    wr(3'd2, 16'h00FC);
    wr(3'd0, 16'd1);
    for (int i = 0; i < 6; i++) smp(16'(i));
    chk(mem_addr, 8'h01, "R3 modulo address");

    // random traffic, checked each cycle against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      if (r[7:0] < 8)
        cyc(r[8], 16'($urandom), 1, 3'($urandom_range(0, 5)), 16'($urandom_range(0, 3) * 2 + 2));
      else if (r[7:0] < 20)
        cyc(r[8], 16'($urandom), 1, 3'd1, 16'($urandom));
      else if (r[7:0] < 30)
        cyc(r[8], 16'($urandom), 1, 3'd4, 16'($urandom));
      else
        cyc(r[8] | r[9], 16'($urandom), 0, 3'($urandom_range(0, 7)), 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule